// File: doc/BRIEF.md
# Highest-Priority Pending Virtual Interrupt Selector

This block looks at a small bank of virtual interrupt list entries, which an external register file supplies, and reports which entry a virtual CPU interface should take next. Each 64-bit entry holds a state code, a group bit, an 8-bit priority, a non-maskable flag and a virtual interrupt number. The block also receives the two group enables and a global enable for the non-maskable feature.

The search follows a fixed order. Only pending entries whose group is enabled are candidates. A lower priority value wins. When two priorities are equal, a non-maskable entry beats a maskable one. When two entries are equal in every respect, the lower index wins. The running best begins at the idle priority 0xFF. A maskable entry at 0xFF can therefore never be chosen, but a non-maskable entry at 0xFF can, because it wins the tie.

The result is held in registers. The index, valid flag, winning priority and winning non-maskable flag follow a change on any input one clock later.

Top module: `lrsel_hppi`

## Requirements
- R1: When both group enables are low, the next cycle shows valid low and priority 0xFF, whatever the entries hold.
- R2: Only entries whose state code (bits 63:62) equals 2'b01 (pending) are candidates. The codes 2'b00 (invalid), 2'b10 (active) and 2'b11 (active and pending) are skipped.
- R3: An entry whose group bit (bit 60; 0 selects group 0, 1 selects group 1) names a disabled group is skipped.
- R4: Among candidates, the one with the numerically lowest priority (bits 55:48) is selected. The search starts from 0xFF, so a maskable candidate at priority 0xFF is never selected.
- R5: A candidate whose priority equals the current best replaces it only if the candidate is non-maskable (bit 59 set) and the current best is not. A non-maskable candidate at 0xFF is therefore selected.
- R6: When the feature enable is low, bit 59 of every entry is treated as zero, and the non-maskable output stays low.
- R7: Among candidates that are identical in priority and non-maskable flag, the lowest index is selected.
- R8: When no candidate is found, the outputs are valid low, index 0, priority 0xFF and non-maskable low.
- R9: The outputs are registered. A synchronous active-low reset loads the idle values of R8, and a change on any input appears on the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp0_en_i | input | 1 | Group 0 enable |
| grp1_en_i | input | 1 | Group 1 enable |
| nmi_feat_en_i | input | 1 | Global enable for the non-maskable feature |
| lr_bank_i | input | NUM_LR*64 | List entries; entry k occupies bits [64k+63:64k] |
| sel_idx_o | output | IDX_W | Index of the selected entry |
| sel_valid_o | output | 1 | A candidate was found |
| sel_prio_o | output | 8 | Priority of the selected entry, or 0xFF when none |
| sel_nmi_o | output | 1 | Effective non-maskable flag of the selected entry |

## Verification
On every cycle, the assertions check the following. With both groups off, the next result is idle. With the feature enable off, the non-maskable output is low. An idle result carries the idle values. Any reported winner was pending in the previous cycle, and its priority matches the entry. The assertions cannot show that the winner was the best candidate. The bench's scenarios show that: the tie-break towards a non-maskable entry, the lowest-index rule, the 0xFF corner and the filters on group and state. The bench also checks the one-cycle latency and the reset values at the ports.

// File: rtl/lrsel_pkg.sv
// Shared definitions for the list-entry selector: field positions inside a
// 64-bit list entry, the state encoding and the per-entry candidate record.
// Assumes every entry is exactly ENTRY_W bits wide.
package lrsel_pkg;

    localparam int ENTRY_W  = 64;
    localparam int PRIO_W   = 8;
    localparam int ST_HI    = 63;
    localparam int ST_LO    = 62;
    localparam int GRP_BIT  = 60;
    localparam int NMI_BIT  = 59;
    localparam int PRIO_HI  = 55;
    localparam int PRIO_LO  = 48;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'b00,
        ST_PENDING  = 2'b01,
        ST_ACTIVE   = 2'b10,
        ST_ACT_PEND = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic              cand;
        logic              nmi;
        logic [PRIO_W-1:0] prio;
    } lr_cand_t;

endpackage

// File: rtl/lrsel_entry_decode.sv
// Decodes one list entry into a candidate record. An entry is a candidate
// only when its state is pending and its group is enabled. The non-maskable
// flag is forced low when the feature enable is off.
// Assumes the entry layout given in lrsel_pkg.
module lrsel_entry_decode
    import lrsel_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic               grp0_en_i,
    input  logic               grp1_en_i,
    input  logic               nmi_feat_en_i,
    output lr_cand_t           cand_o
);

    lr_state_e st;
    logic      grp_ok;

    // Extract the fields and qualify the entry as a candidate.
    always_comb begin
        st          = lr_state_e'(entry_i[ST_HI:ST_LO]);
        grp_ok      = entry_i[GRP_BIT] ? grp1_en_i : grp0_en_i;
        cand_o.cand = (st == ST_PENDING) && grp_ok;
        cand_o.nmi  = nmi_feat_en_i && entry_i[NMI_BIT];
        cand_o.prio = entry_i[PRIO_HI:PRIO_LO];
    end

endmodule

// File: rtl/lrsel_rank_stage.sv
// One step of the ordered scan. It takes the best result so far and one
// candidate, and passes on whichever ranks higher. A candidate replaces the
// best when its priority is strictly lower, or when the priorities are equal
// and only the candidate is non-maskable. Because the comparison is strict,
// an earlier entry wins a full tie.
// Assumes the stages are chained in ascending index order.
module lrsel_rank_stage
    import lrsel_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int IDX   = 0
) (
    input  logic              in_valid_i,
    input  logic [PRIO_W-1:0] in_prio_i,
    input  logic              in_nmi_i,
    input  logic [IDX_W-1:0]  in_idx_i,
    input  lr_cand_t          cand_i,
    output logic              out_valid_o,
    output logic [PRIO_W-1:0] out_prio_o,
    output logic              out_nmi_o,
    output logic [IDX_W-1:0]  out_idx_o
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

    logic lower;
    logic tie_nmi;
    logic take;

    // Decide whether this candidate displaces the running best.
    always_comb begin
        lower   = cand_i.prio < in_prio_i;
        tie_nmi = (cand_i.prio == in_prio_i) && cand_i.nmi && !in_nmi_i;
        take    = cand_i.cand && (lower || tie_nmi);
    end

    // Forward either the candidate or the incoming best.
    always_comb begin
        if (take) begin
            out_valid_o = 1'b1;
            out_prio_o  = cand_i.prio;
            out_nmi_o   = cand_i.nmi;
            out_idx_o   = MY_IDX;
        end else begin
            out_valid_o = in_valid_i;
            out_prio_o  = in_prio_i;
            out_nmi_o   = in_nmi_i;
            out_idx_o   = in_idx_i;
        end
    end

endmodule

// File: rtl/lrsel_hppi.sv
// Top of the selector. It decodes NUM_LR list entries, ranks them through an
// ascending chain of stages seeded with the idle priority, and registers the
// winner. The outputs follow the inputs by one clock.
// Assumes 1 <= NUM_LR <= 16 and a synchronous active-low reset.
module lrsel_hppi
    import lrsel_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int BANK_W = NUM_LR * ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp0_en_i,
    input  logic              grp1_en_i,
    input  logic              nmi_feat_en_i,
    input  logic [BANK_W-1:0] lr_bank_i,
    output logic [IDX_W-1:0]  sel_idx_o,
    output logic              sel_valid_o,
    output logic [PRIO_W-1:0] sel_prio_o,
    output logic              sel_nmi_o
);

    lr_cand_t          cands    [NUM_LR];
    logic              ch_valid [NUM_LR+1];
    logic [PRIO_W-1:0] ch_prio  [NUM_LR+1];
    logic              ch_nmi   [NUM_LR+1];
    logic [IDX_W-1:0]  ch_idx   [NUM_LR+1];

    // Seed the chain with "nothing found yet" at the idle priority.
    always_comb begin
        ch_valid[0] = 1'b0;
        ch_prio[0]  = PRIO_IDLE;
        ch_nmi[0]   = 1'b0;
        ch_idx[0]   = '0;
    end

    for (genvar k = 0; k < NUM_LR; k++) begin : g_lr
        lrsel_entry_decode u_dec (
            .entry_i       (lr_bank_i[k*ENTRY_W +: ENTRY_W]),
            .grp0_en_i     (grp0_en_i),
            .grp1_en_i     (grp1_en_i),
            .nmi_feat_en_i (nmi_feat_en_i),
            .cand_o        (cands[k])
        );

        lrsel_rank_stage #(.IDX_W(IDX_W), .IDX(k)) u_stage (
            .in_valid_i  (ch_valid[k]),
            .in_prio_i   (ch_prio[k]),
            .in_nmi_i    (ch_nmi[k]),
            .in_idx_i    (ch_idx[k]),
            .cand_i      (cands[k]),
            .out_valid_o (ch_valid[k+1]),
            .out_prio_o  (ch_prio[k+1]),
            .out_nmi_o   (ch_nmi[k+1]),
            .out_idx_o   (ch_idx[k+1])
        );
    end

    // Register the chain result; reset loads the idle values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_o <= 1'b0;
            sel_prio_o  <= PRIO_IDLE;
            sel_nmi_o   <= 1'b0;
            sel_idx_o   <= '0;
        end else begin
            sel_valid_o <= ch_valid[NUM_LR];
            sel_prio_o  <= ch_prio[NUM_LR];
            sel_nmi_o   <= ch_nmi[NUM_LR];
            sel_idx_o   <= ch_idx[NUM_LR];
        end
    end

    // ---------------- assertions ----------------
    logic [BANK_W-1:0]  chk_bank_q;
    logic [ENTRY_W-1:0] chk_entry;

    // Keep the previous bank so the registered winner can be compared with it.
    always_ff @(posedge clk) begin
        chk_bank_q <= lr_bank_i;
    end

    // Pick out the entry that the registered index refers to.
    always_comb begin
        chk_entry = chk_bank_q[int'(sel_idx_o)*ENTRY_W +: ENTRY_W];
    end

    a_r1_groups_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp0_en_i && !grp1_en_i) |=> (!sel_valid_o && sel_prio_o == PRIO_IDLE));

    a_r6_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_feat_en_i |=> !sel_nmi_o);

    a_r8_idle_values: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_prio_o == PRIO_IDLE && !sel_nmi_o && sel_idx_o == '0));

    a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (chk_entry[ST_HI:ST_LO] == ST_PENDING
                         && chk_entry[PRIO_HI:PRIO_LO] == sel_prio_o));

endmodule

// File: tb/lrsel_hppi_tb.sv
module lrsel_hppi_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NLR = 4;
    localparam int BW  = NLR * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en0 = 1'b0, en1 = 1'b0, nmif = 1'b0;
    logic [BW-1:0] bank = '0;
    logic [1:0]    idx;
    logic          valid;
    logic [7:0]    prio;
    logic          nmi;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsel_hppi #(.NUM_LR(NLR)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .grp0_en_i(en0), .grp1_en_i(en1), .nmi_feat_en_i(nmif),
        .lr_bank_i(bank),
        .sel_idx_o(idx), .sel_valid_o(valid), .sel_prio_o(prio), .sel_nmi_o(nmi)
    );

    // Entry builder: state[63:62], group[60], nmi[59], prio[55:48], id[31:0].
    function automatic logic [63:0] mk(input logic [1:0] st, input logic g,
                                       input logic n, input logic [7:0] p);
        return {st, 1'b0, g, n, 3'b000, p, 16'h0000, 24'h0, p};
    endfunction

    localparam logic [1:0] PD = 2'b01, IV = 2'b00, AC = 2'b10, AP = 2'b11;

    typedef struct packed {
        logic          e0, e1, nf;
        logic [BW-1:0] bank;   // {entry3, entry2, entry1, entry0}
        logic          v;
        logic [1:0]    i;
        logic [7:0]    p;
        logic          n;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1: both groups off
        '{1'b0,1'b0,1'b0,{mk(PD,0,0,8'd10),mk(PD,0,0,8'd10),mk(PD,1,0,8'd10),mk(PD,0,0,8'd10)},1'b0,2'd0,8'hFF,1'b0,4'd1},
        // R2: only pending counts
        '{1'b1,1'b1,1'b0,{mk(PD,0,0,8'd40),mk(AP,0,0,8'd2),mk(IV,0,0,8'd3),mk(AC,0,0,8'd5)},1'b1,2'd3,8'd40,1'b0,4'd2},
        // R3: group 1 off
        '{1'b1,1'b0,1'b0,{mk(PD,0,0,8'd20),mk(PD,1,0,8'd0),mk(PD,0,0,8'd9),mk(PD,1,0,8'd1)},1'b1,2'd1,8'd9,1'b0,4'd3},
        // R3: group 0 off
        '{1'b0,1'b1,1'b0,{mk(PD,0,0,8'd20),mk(PD,1,0,8'd0),mk(PD,0,0,8'd9),mk(PD,1,0,8'd1)},1'b1,2'd2,8'd0,1'b0,4'd3},
        // R4: lowest value wins
        '{1'b1,1'b1,1'b0,{mk(PD,0,0,8'd21),mk(PD,0,0,8'd25),mk(PD,0,0,8'd20),mk(PD,0,0,8'd30)},1'b1,2'd1,8'd20,1'b0,4'd4},
        // R4: maskable 0xFF never selected
        '{1'b1,1'b1,1'b1,{mk(PD,0,0,8'hFF),mk(PD,0,0,8'hFF),mk(PD,1,0,8'hFF),mk(PD,0,0,8'hFF)},1'b0,2'd0,8'hFF,1'b0,4'd4},
        // R5: tie goes to the non-maskable entry
        '{1'b1,1'b1,1'b1,{mk(PD,0,0,8'd8),mk(PD,0,1,8'd8),mk(PD,0,0,8'd8),mk(PD,0,0,8'd8)},1'b1,2'd2,8'd8,1'b1,4'd5},
        // R5: a lower priority still beats a non-maskable entry
        '{1'b1,1'b1,1'b1,{mk(IV,0,0,8'd0),mk(IV,0,0,8'd0),mk(PD,0,1,8'd6),mk(PD,0,0,8'd4)},1'b1,2'd0,8'd4,1'b0,4'd5},
        // R6: flag ignored when the feature is off
        '{1'b1,1'b1,1'b0,{mk(PD,0,0,8'd8),mk(PD,0,1,8'd8),mk(PD,0,0,8'd8),mk(PD,0,0,8'd8)},1'b1,2'd0,8'd8,1'b0,4'd6},
        // R7: full tie goes to the lowest index
        '{1'b1,1'b1,1'b0,{mk(PD,1,0,8'd7),mk(AC,0,0,8'd1),mk(PD,0,0,8'd7),mk(IV,0,0,8'd1)},1'b1,2'd1,8'd7,1'b0,4'd7},
        // R5: non-maskable entry at 0xFF is selected
        '{1'b1,1'b1,1'b1,{mk(PD,0,1,8'hFF),mk(PD,0,0,8'hFF),mk(PD,0,0,8'hFF),mk(PD,0,0,8'hFF)},1'b1,2'd3,8'hFF,1'b1,4'd5},
        // R8: nothing pending
        '{1'b1,1'b1,1'b1,{mk(AC,0,1,8'd1),mk(AP,0,0,8'd2),mk(IV,1,0,8'd3),mk(AC,1,1,8'd0)},1'b0,2'd0,8'hFF,1'b0,4'd8},
        // R7: two non-maskable entries tie, so the lower index wins
        '{1'b1,1'b1,1'b1,{mk(PD,0,1,8'd8),mk(PD,0,0,8'd8),mk(PD,0,1,8'd8),mk(PD,0,1,8'd8)},1'b1,2'd0,8'd8,1'b1,4'd7}
    };

    task automatic expect_out(input logic v, input logic [1:0] i, input logic [7:0] p,
                              input logic n, input int req);
        checks++;
        if (valid !== v || idx !== i || prio !== p || nmi !== n) begin
            errors++;
            $display("FAIL R%0d: got v=%b i=%0d p=%h n=%b expected v=%b i=%0d p=%h n=%b",
                     req, valid, idx, prio, nmi, v, i, p, n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset loads idle values even with a valid candidate present
        en0 = 1'b1; en1 = 1'b1; bank = {3{64'h0}} | {192'h0, mk(PD,0,0,8'd3)};
        repeat (3) @(negedge clk);
        expect_out(1'b0, 2'd0, 8'hFF, 1'b0, 9);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b1, 2'd0, 8'd3, 1'b0, 9);

        // Walk the vector table.
        for (int k = 0; k < NV; k++) begin
            en0 = VECS[k].e0; en1 = VECS[k].e1; nmif = VECS[k].nf; bank = VECS[k].bank;
            @(negedge clk);
            expect_out(VECS[k].v, VECS[k].i, VECS[k].p, VECS[k].n, int'(VECS[k].req));
        end

        // R9: output holds until the next edge, then updates.
        en0 = 1'b1; en1 = 1'b1; nmif = 1'b0;
        bank = {mk(IV,0,0,8'd0), mk(IV,0,0,8'd0), mk(PD,0,0,8'd12), mk(IV,0,0,8'd0)};
        @(negedge clk);
        expect_out(1'b1, 2'd1, 8'd12, 1'b0, 9);
        bank = {mk(PD,0,0,8'd2), mk(IV,0,0,8'd0), mk(PD,0,0,8'd12), mk(IV,0,0,8'd0)};
        #1;
        expect_out(1'b1, 2'd1, 8'd12, 1'b0, 9);
        @(negedge clk);
        expect_out(1'b1, 2'd3, 8'd2, 1'b0, 9);

        // R8 and R9: reset mid-run returns the idle values.
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(1'b0, 2'd0, 8'hFF, 1'b0, 8);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b1, 2'd3, 8'd2, 1'b0, 9);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule